// File: doc/BRIEF.md
# Two-Wire Control Target for a Current-Sink DAC

This block is the serial control front end of a 10-bit current-sink DAC. It acts as a target on a standard I2C bus and answers at one fixed 7-bit address. It holds a single 16-bit control word. The word carries a soft power-down flag at the top bit and the 10-bit converter code in the middle. A host sets the word with a two-byte write and can fetch it again with a two-byte read. Both transfers send the upper byte first.

A fast system clock oversamples SCL and SDA through synchronizer chains. The serial engine detects START and STOP conditions, matches the address and acknowledges bytes. It drives SDA only by pulling it low through an enable output. The stored word feeds registered outputs: the converter code, and a power-down signal that is the OR of the stored flag and an external power-down pin. A write takes effect only once both bytes have arrived and the second one has been acknowledged. The design has no clock stretching, no general-call response and no 10-bit addressing.

Top module: `dac_ctl_target`

## Requirements
- R1: The target acknowledges only the address 7'b0001100. A byte carrying any other address gets no ACK, and SDA is released until the next START, including during any data bytes that follow.
- R2: When the direction bit after the address is 0 (write), the target ACKs the address and both data bytes. The first byte becomes word bits 15..8 and the second becomes bits 7..0. `dac_code` then equals word bits 13..4.
- R3: When the direction bit is 1 (read), the target returns the stored word's bits 15..8 and then bits 7..0, MSB first. The master ACKs the first byte and NACKs the second, after which SDA stays released.
- R4: `pd_out` is 1 whenever the stored bit 15 is 1 or `pd_pin` is 1. It is 0 only when both are 0.
- R5: `dac_code` and the stored power-down flag change together, and only after the second data byte of a write has been acknowledged. A write cut short by STOP after one data byte leaves the outputs and the stored word unchanged.
- R6: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) abort any transfer. A repeated START begins a fresh address phase, and a complete write that follows it is applied.
- R7: SDA is only ever pulled low through `sda_pull`, and `sda_pull` changes only while SCL is low.
- R8: After reset the stored word is 16'h0000, `dac_code` is 0, and `pd_out` follows `pd_pin` alone.
- R9: Bits 14 and 3..0 are stored as written and returned on readback. They have no effect on `dac_code` or `pd_out`.
- R10: In a write, any byte after the second gets no ACK and does not alter the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| pd_pin | input | 1 | External power-down request, active high |
| dac_code | output | 10 | Converter code taken from word bits 13..4 |
| pd_out | output | 1 | Power-down to the converter: stored bit 15 OR `pd_pin` |

## Verification
The bench aims at the points where a target that counts bits or edges wrongly would misbehave. It sends a foreign address followed by a data byte: a design that matched too loosely would acknowledge, or would pull SDA during the data byte. It cuts a write short with STOP after one byte, and again with a repeated START followed by a full write. A design that applied each byte as it arrived would show a half-updated code, and one that ignored the repeated START would lose the second write. It also sends a third byte, reads back words that have the unused bits set, and toggles the external pin under random words. These catch a misplaced code field, an off-by-one readback shift, or a power-down OR that leaves out one of its two sources.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_W,
    ST_TX,
    ST_ACK_R,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/dacctl_bus_sync.sv
module dacctl_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_raw;
          sda_chain <= sda_raw;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
          sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_chain[STAGES-1];
      sda_d <= sda_chain[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_chain[STAGES-1];
    sda_s     = sda_chain[STAGES-1];
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_det = scl_s & scl_d & sda_d & ~sda_s;
    stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  end

  // START and STOP are both line changes with SCL held high, so they never coincide
  p_start_stop_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));
  // A rising SCL edge is never flagged together with a falling one
  p_edge_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise && scl_fall));
endmodule

// File: rtl/dacctl_target_fsm.sv
module dacctl_target_fsm
  import dacctl_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter logic [6:0]  ADDR   = 7'b0001100,
  parameter int          WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word
);
  localparam int NBYTES = WORD_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  tgt_state_t        state;
  logic [2:0]        bitcnt;
  logic [7:0]        shreg;
  logic              full;
  logic              rw;
  logic              mack;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] txw;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      full     <= 1'b0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      idx      <= '0;
      acc      <= '0;
      txw      <= '0;
      sda_pull <= 1'b0;
      wr_word  <= '0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      full     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      full     <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full   <= 1'b0;
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == ADDR) begin
                sda_pull <= 1'b1;
                rw       <= shreg[0];
                state    <= ST_ACK_A;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              sda_pull <= 1'b1;
              acc      <= {acc[WORD_W-9:0], shreg};
              state    <= ST_ACK_W;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            idx <= '0;
            if (rw) begin
              txw      <= rd_word;
              sda_pull <= ~rd_word[WORD_W-1];
              state    <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_RX;
            end
          end
        end
        ST_ACK_W: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            if (idx == LAST) begin
              wr_en   <= 1'b1;
              wr_word <= acc;
              state   <= ST_SKIP;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) full <= 1'b1;
          end else if (scl_fall) begin
            txw <= txw << 1;
            if (full) begin
              full     <= 1'b0;
              bitcnt   <= '0;
              sda_pull <= 1'b0;
              state    <= ST_ACK_R;
            end else begin
              sda_pull <= ~txw[WORD_W-2];
            end
          end
        end
        ST_ACK_R: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack && idx != LAST) begin
              idx      <= idx + 1'b1;
              sda_pull <= ~txw[WORD_W-1];
              state    <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R7: the pull-down enable only moves while the synchronized SCL is low
  p_pull_scl_low_r7: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !scl_s);
  // R1: a target that has dropped out of the transfer never drives the line
  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_pull);
  // R6: a START always leads into a fresh address phase
  p_start_addr_r6: assert property (@(posedge clk) disable iff (rst)
    $past(start_det) |-> (state == ST_ADDR));
  // R5: the word is handed over only on leaving an acknowledge slot of a write
  p_commit_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(state) == ST_ACK_W));
endmodule

// File: rtl/dacctl_word_reg.sv
module dacctl_word_reg #(
  parameter int WORD_W   = 16,
  parameter int CODE_W   = 10,
  parameter int CODE_LSB = 4,
  parameter int PD_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              pd_pin,
  output logic [WORD_W-1:0] word_q,
  output logic [CODE_W-1:0] dac_code,
  output logic              pd_out
);
  logic soft_next;

  always_comb begin
    if (rst)        soft_next = 1'b0;
    else if (wr_en) soft_next = wr_word[PD_BIT];
    else            soft_next = word_q[PD_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      dac_code <= '0;
    end else if (wr_en) begin
      word_q   <= wr_word;
      dac_code <= wr_word[CODE_LSB +: CODE_W];
    end
    pd_out <= soft_next | pd_pin;
  end

  // R5: the code only moves in the cycle after a completed write
  p_code_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code)) |-> $past(wr_en));
  // R4: the external pin alone forces power-down
  p_pin_forces_r4: assert property (@(posedge clk) disable iff (rst)
    $past(pd_pin) |-> pd_out);
  // R4: with the pin low the output tracks the stored flag
  p_soft_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(pd_pin) && !$past(wr_en)) |-> (pd_out == word_q[PD_BIT]));
endmodule

// File: rtl/dac_ctl_target.sv
module dac_ctl_target #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b0001100,
  parameter int         WORD_W      = 16,
  parameter int         CODE_W      = 10,
  parameter int         CODE_LSB    = 4,
  parameter int         PD_BIT      = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic              pd_pin,
  output logic [CODE_W-1:0] dac_code,
  output logic              pd_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] word_q;

  dacctl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dacctl_target_fsm #(.ADDR_W(7), .ADDR(DEV_ADDR), .WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_word(word_q), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_word(wr_word)
  );

  dacctl_word_reg #(.WORD_W(WORD_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
                    .PD_BIT(PD_BIT)) u_word (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .pd_pin(pd_pin),
    .word_q(word_q), .dac_code(dac_code), .pd_out(pd_out)
  );
endmodule

// File: tb/dac_ctl_target_test.sv
`timescale 1ns/1ps
module dac_ctl_target_test;
  localparam int QTR = 20;
  localparam logic [6:0] GOOD = 7'b0001100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic pd_pin = 1'b0;
  logic sda_pull;
  logic sda_line;
  logic [9:0] dac_code;
  logic pd_out;

  int checks = 0;
  int errors = 0;
  int r7_viol = 0;
  logic prev_pull = 1'b0;
  logic [15:0] model = 16'h0000;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  dac_ctl_target uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .pd_pin(pd_pin), .dac_code(dac_code), .pd_out(pd_out)
  );

  // R7 monitor: count pull-enable changes seen while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_pull != prev_pull && scl) r7_viol++;
    prev_pull <= sda_pull;
  end

  function automatic logic [9:0] exp_code(input logic [15:0] w);
    return w[13:4];
  endfunction
  function automatic logic exp_pd(input logic [15:0] w, input logic pin);
    return w[15] | pin;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); acked = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic write_word(input logic [15:0] w, output logic a0, output logic a1,
                            output logic a2);
    i2c_start();
    send_byte({GOOD, 1'b0}, a0);
    send_byte(w[15:8], a1);
    send_byte(w[7:0], a2);
    i2c_stop();
    repeat (10) @(negedge clk);
  endtask

  task automatic read_word(output logic [15:0] w, output logic a0);
    logic [7:0] hi, lo;
    i2c_start();
    send_byte({GOOD, 1'b1}, a0);
    recv_byte(1'b1, hi);
    recv_byte(1'b0, lo);
    i2c_stop();
    w = {hi, lo};
    repeat (10) @(negedge clk);
  endtask

  task automatic run_all();
    logic a0, a1, a2, a3;
    logic [15:0] rd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 code after reset", dac_code, 0);
    chk("R8 pd_out after reset", pd_out, 0);
    pd_pin = 1'b1; repeat (3) @(negedge clk);
    chk("R8/R4 pin drives pd_out", pd_out, 1);
    pd_pin = 1'b0; repeat (3) @(negedge clk);
    read_word(rd, a0);
    chk("R1 addr ack on read", a0, 1);
    chk("R8/R3 reset word readback", rd, 16'h0000);

    // R1: foreign address, then a data byte
    i2c_start();
    send_byte({7'b0001101, 1'b0}, a0);
    send_byte(8'h00, a1);
    i2c_stop();
    repeat (10) @(negedge clk);
    chk("R1 foreign address not acked", a0, 0);
    chk("R1 data after foreign address not acked", a1, 0);
    chk("R1 outputs untouched", dac_code, 0);

    // R2/R4 directed write
    write_word(16'hA5F3, a0, a1, a2);
    model = 16'hA5F3;
    chk("R2 address ack", a0, 1);
    chk("R2 byte1 ack", a1, 1);
    chk("R2 byte2 ack", a2, 1);
    chk("R2 code field", dac_code, exp_code(model));
    chk("R4 soft power-down", pd_out, exp_pd(model, 1'b0));
    read_word(rd, a0);
    chk("R3 readback", rd, model);

    // R5 abort after one byte by STOP
    i2c_start();
    send_byte({GOOD, 1'b0}, a0);
    send_byte(8'h12, a1);
    i2c_stop();
    repeat (10) @(negedge clk);
    chk("R5 code unchanged after STOP abort", dac_code, exp_code(model));
    chk("R5 pd unchanged after STOP abort", pd_out, exp_pd(model, 1'b0));
    read_word(rd, a0);
    chk("R5 word unchanged after STOP abort", rd, model);

    // R6 abort by repeated START, then full write
    i2c_start();
    send_byte({GOOD, 1'b0}, a0);
    send_byte(8'h7F, a1);
    i2c_start();
    send_byte({GOOD, 1'b0}, a0);
    send_byte(8'h40, a1);
    send_byte(8'h10, a2);
    i2c_stop();
    repeat (10) @(negedge clk);
    model = 16'h4010;
    chk("R6 repeated START address ack", a0, 1);
    chk("R6 write after repeated START", dac_code, exp_code(model));
    chk("R6 pd after repeated START", pd_out, 0);

    // R10 third byte
    i2c_start();
    send_byte({GOOD, 1'b0}, a0);
    send_byte(8'h3C, a1);
    send_byte(8'h5A, a2);
    send_byte(8'hFF, a3);
    i2c_stop();
    repeat (10) @(negedge clk);
    model = 16'h3C5A;
    chk("R10 third byte not acked", a3, 0);
    read_word(rd, a0);
    chk("R10 word from first two bytes", rd, model);

    // R9 unused bits only
    write_word(16'h400F, a0, a1, a2);
    model = 16'h400F;
    chk("R9 unused bits leave code zero", dac_code, 0);
    chk("R9 unused bits leave pd low", pd_out, 0);
    read_word(rd, a0);
    chk("R9 unused bits read back", rd, model);

    // Boundary: all ones code with pin high
    write_word(16'h3FF0, a0, a1, a2);
    model = 16'h3FF0;
    chk("R2 full-scale code", dac_code, 10'h3FF);
    pd_pin = 1'b1; repeat (3) @(negedge clk);
    chk("R4 pin with soft bit clear", pd_out, 1);
    pd_pin = 1'b0; repeat (3) @(negedge clk);
    chk("R4 both low", pd_out, 0);

    // Random words and pin levels
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED);
    end
    for (int n = 0; n < 12; n++) begin
      logic [15:0] w;
      logic pin;
      w = 16'($urandom);
      pin = 1'($urandom);
      pd_pin = pin;
      write_word(w, a0, a1, a2);
      model = w;
      chk("R2 random acks", {a0, a1, a2}, 3'b111);
      chk("R2 random code", dac_code, exp_code(model));
      chk("R4 random pd", pd_out, exp_pd(model, pin));
      read_word(rd, a0);
      chk("R3/R9 random readback", rd, model);
    end
    pd_pin = 1'b0;
    chk("R7 pull changes only with SCL low", r7_viol, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule